// File: doc/BRIEF.md
# Center-Aligned Four-Channel PWM Modulator

This block drives the four half-bridge gate signals of a two-phase motor from two signed duty commands, one per phase. Phase A normally carries a cosine command and phase B a sine command. A single signed up/down counter forms a symmetric triangular carrier. The counter steps only on cycles where a clock-enable pulse from a divider is high, so the divider sets the PWM frequency.

For each phase, the command is captured only at the bottom turnaround of the carrier. From the captured value the block keeps a positive threshold (the command) and a negated threshold. The left gate of a phase is high while its positive threshold is above the carrier. The right gate is high while its negated threshold is above the carrier. One command therefore produces complementary mean voltages on the two bridge legs. All four comparators share the same carrier, so the four edges are synchronised. A one-cycle pulse marks the cycle in which freshly captured thresholds take effect, so that the command source can align its updates.

Top module: `tri_pwm4`

## Requirements
- R1: A synchronous reset sets the carrier to 0 with the counting direction up, clears all four thresholds to 0, and drives all four gates and the bottom pulse to 0.
- R2: The carrier changes by exactly one on every clock edge where `step_en` is 1. It holds its value on every edge where `step_en` is 0.
- R3: The carrier stays within +2047 and −2047. When it is counting up and sits at +2047, the next step takes it to +2046 and the direction turns to down. When it is counting down and sits at −2047, the next step takes it to −2046 and the direction turns to up.
- R4: The commands are sampled only on the step that leaves −2047 while counting down. A change on `cmd_a` or `cmd_b` at any other time has no effect on the gates until that step.
- R5: `gate_a_left` is 1 exactly when the captured phase A command, compared as a signed value, is greater than the carrier. `gate_b_left` follows the same rule with the phase B command.
- R6: `gate_a_right` is 1 exactly when the negated captured phase A command is greater than the carrier. `gate_b_right` follows the same rule with the negated phase B command.
- R7: A command of −2048 (0x800) is captured as −2047, so its negated threshold is +2047 and does not wrap.
- R8: `bottom_pulse` is 1 for exactly one cycle, the first cycle in which newly captured thresholds drive the gates. In that cycle the carrier reads −2046.
- R9: Suppose `step_en` is held at 1 and the captured threshold is h. Over one carrier period of 8188 cycles, measured from one bottom pulse to the next, the gate is high for max(0, 2·(h+2047)−1) cycles. This gives a mean of (h/2047+1)/2 of full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Carrier step enable from the PWM frequency divider |
| cmd_a | input | 12 | Signed phase A duty command |
| cmd_b | input | 12 | Signed phase B duty command |
| carrier | output | 12 | Signed triangular carrier value |
| bottom_pulse | output | 1 | One-cycle mark when new thresholds take effect |
| gate_a_left | output | 1 | Phase A left half-bridge gate |
| gate_a_right | output | 1 | Phase A right half-bridge gate |
| gate_b_left | output | 1 | Phase B left half-bridge gate |
| gate_b_right | output | 1 | Phase B right half-bridge gate |

## Verification
The first pattern holds the commands constant with a step on every cycle. It walks the carrier through both turnarounds and measures the duty cycle over a whole period, which shows whether the top and bottom reversals repeat or skip a value. Commands that change on every cycle in the middle of a period separate capture at the bottom only from capture at any other time. The pattern with −2048 and +2047 commands separates saturation from wraparound of the negated threshold. Long random runs with an irregular `step_en` and random commands, including extreme values, check that the carrier holds between enables and that the comparisons stay correct at every carrier value.

// File: rtl/tri_pwm4_pkg.sv
package tri_pwm4_pkg;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } ramp_dir_e;

   localparam int unsigned PHASES   = 2;
   localparam int unsigned CHANNELS = 2 * PHASES;

endpackage

// File: rtl/tri_pwm4_carrier.sv
module tri_pwm4_carrier
   import tri_pwm4_pkg::*;
#(
   parameter int unsigned CW = 12
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 step_en,
   output logic signed [CW-1:0] cnt_o,
   output logic                 load_o,
   output logic                 bottom_o
);

   localparam logic signed [CW-1:0] LIM_HI = {1'b0, {(CW-1){1'b1}}};
   localparam logic signed [CW-1:0] LIM_LO = {1'b1, {(CW-2){1'b0}}, 1'b1};
   localparam logic signed [CW-1:0] ONE    = {{(CW-1){1'b0}}, 1'b1};

   logic signed [CW-1:0] cnt_q, cnt_d;
   ramp_dir_e            dir_q, dir_d;
   logic                 bottom_q;

   always_comb begin
      cnt_d = cnt_q;
      dir_d = dir_q;
      if (step_en) begin
         if (dir_q == DIR_UP) begin
            if (cnt_q == LIM_HI) begin
               dir_d = DIR_DOWN;
               cnt_d = cnt_q - ONE;
            end else begin
               cnt_d = cnt_q + ONE;
            end
         end else begin
            if (cnt_q == LIM_LO) begin
               dir_d = DIR_UP;
               cnt_d = cnt_q + ONE;
            end else begin
               cnt_d = cnt_q - ONE;
            end
         end
      end
   end

   assign load_o = step_en && (dir_q == DIR_DOWN) && (cnt_q == LIM_LO);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         dir_q    <= DIR_UP;
         bottom_q <= 1'b0;
      end else begin
         cnt_q    <= cnt_d;
         dir_q    <= dir_d;
         bottom_q <= load_o;
      end
   end

   assign cnt_o    = cnt_q;
   assign bottom_o = bottom_q;

   assert_range_R3: assert property (@(posedge clk) disable iff (rst)
      (cnt_q <= LIM_HI) && (cnt_q >= LIM_LO));

   assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> $stable(cnt_q));

   assert_move_R2: assert property (@(posedge clk) disable iff (rst)
      step_en |=> (cnt_q != $past(cnt_q)));

   assert_top_turn_R3: assert property (@(posedge clk) disable iff (rst)
      (step_en && dir_q == DIR_UP && cnt_q == LIM_HI) |=> (cnt_q == LIM_HI - ONE));

   assert_bottom_pos_R8: assert property (@(posedge clk) disable iff (rst)
      bottom_q |-> (cnt_q == LIM_LO + ONE));

   assert_bottom_single_R8: assert property (@(posedge clk) disable iff (rst)
      bottom_q |=> !bottom_q);

endmodule

// File: rtl/tri_pwm4_threshold.sv
module tri_pwm4_threshold #(
   parameter int unsigned CW       = 12,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 load_i,
   input  logic signed [CW-1:0] cmd_i,
   output logic signed [CW-1:0] hi_o,
   output logic signed [CW-1:0] lo_o
);

   localparam logic signed [CW-1:0] MOST_NEG = {1'b1, {(CW-1){1'b0}}};
   localparam logic signed [CW-1:0] LIM_LO   = {1'b1, {(CW-2){1'b0}}, 1'b1};

   logic signed [CW-1:0] cmd_s;
   logic signed [CW-1:0] hi_q, lo_q;

   generate
      if (SATURATE) begin : g_sat
         assign cmd_s = (cmd_i == MOST_NEG) ? LIM_LO : cmd_i;
      end else begin : g_raw
         assign cmd_s = cmd_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (load_i) begin
         hi_q <= cmd_s;
         lo_q <= -cmd_s;
      end
   end

   assign hi_o = hi_q;
   assign lo_o = lo_q;

   assert_latch_only_R4: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> ($stable(hi_q) && $stable(lo_q)));

   assert_mirror_R6: assert property (@(posedge clk) disable iff (rst)
      (lo_q == -hi_q));

   generate
      if (SATURATE) begin : g_sat_chk
         assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
            (hi_q != MOST_NEG) && (lo_q != MOST_NEG));
      end
   endgenerate

endmodule

// File: rtl/tri_pwm4_compare.sv
module tri_pwm4_compare #(
   parameter int unsigned CW      = 12,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic signed [CW-1:0] carrier_i,
   input  logic signed [CW-1:0] thr_i,
   output logic                 gate_o
);

   logic above;
   assign above = (thr_i > carrier_i);

   generate
      if (REG_OUT) begin : g_reg
         logic gate_q;
         always_ff @(posedge clk) begin
            if (rst) gate_q <= 1'b0;
            else     gate_q <= above;
         end
         assign gate_o = gate_q;
      end else begin : g_comb
         assign gate_o = above;
      end
   endgenerate

endmodule

// File: rtl/tri_pwm4.sv
module tri_pwm4
   import tri_pwm4_pkg::*;
#(
   parameter int unsigned CW       = 12,
   parameter bit          SATURATE = 1'b1,
   parameter bit          REG_OUT  = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 step_en,
   input  logic signed [CW-1:0] cmd_a,
   input  logic signed [CW-1:0] cmd_b,
   output logic signed [CW-1:0] carrier,
   output logic                 bottom_pulse,
   output logic                 gate_a_left,
   output logic                 gate_a_right,
   output logic                 gate_b_left,
   output logic                 gate_b_right
);

   initial begin
      assert (CW >= 4 && CW <= 30)
         else $error("tri_pwm4: CW must lie in 4..30");
   end

   logic signed [CW-1:0] cnt;
   logic                 load;
   logic signed [CW-1:0] cmd_v [PHASES];
   logic signed [CW-1:0] thr_hi [PHASES];
   logic signed [CW-1:0] thr_lo [PHASES];
   logic [CHANNELS-1:0]  gate;

   assign cmd_v[0] = cmd_a;
   assign cmd_v[1] = cmd_b;

   tri_pwm4_carrier #(.CW(CW)) u_carrier (
      .clk      (clk),
      .rst      (rst),
      .step_en  (step_en),
      .cnt_o    (cnt),
      .load_o   (load),
      .bottom_o (bottom_pulse)
   );

   generate
      for (genvar p = 0; p < PHASES; p++) begin : g_phase
         tri_pwm4_threshold #(.CW(CW), .SATURATE(SATURATE)) u_thr (
            .clk    (clk),
            .rst    (rst),
            .load_i (load),
            .cmd_i  (cmd_v[p]),
            .hi_o   (thr_hi[p]),
            .lo_o   (thr_lo[p])
         );
      end

      for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
         tri_pwm4_compare #(.CW(CW), .REG_OUT(REG_OUT)) u_cmp (
            .clk       (clk),
            .rst       (rst),
            .carrier_i (cnt),
            .thr_i     ((c % 2 == 0) ? thr_hi[c/2] : thr_lo[c/2]),
            .gate_o    (gate[c])
         );
      end
   endgenerate

   assign carrier      = cnt;
   assign gate_a_left  = gate[0];
   assign gate_a_right = gate[1];
   assign gate_b_left  = gate[2];
   assign gate_b_right = gate[3];

   assert_reset_R1: assert property (@(posedge clk)
      rst |=> (carrier == '0 && !bottom_pulse && gate == '0));

   generate
      if (!REG_OUT) begin : g_gate_chk
         assert_left_R5: assert property (@(posedge clk) disable iff (rst)
            gate_a_left |-> (thr_hi[0] > carrier));
         assert_right_R6: assert property (@(posedge clk) disable iff (rst)
            gate_b_right |-> (thr_lo[1] > carrier));
      end
   endgenerate

endmodule

// File: tb/tri_pwm4_test.sv
module tri_pwm4_test;

   localparam int CW  = 12;
   localparam int MAX = 2047;
   localparam int MIN = -2047;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic step_en = 1'b0;
   logic signed [CW-1:0] cmd_a = '0;
   logic signed [CW-1:0] cmd_b = '0;
   logic signed [CW-1:0] carrier;
   logic bottom_pulse, gate_a_left, gate_a_right, gate_b_left, gate_b_right;

   always #5 clk = ~clk;

   tri_pwm4 uut (
      .clk(clk), .rst(rst), .step_en(step_en), .cmd_a(cmd_a), .cmd_b(cmd_b),
      .carrier(carrier), .bottom_pulse(bottom_pulse),
      .gate_a_left(gate_a_left), .gate_a_right(gate_a_right),
      .gate_b_left(gate_b_left), .gate_b_right(gate_b_right)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int m_cnt = 0;
   bit m_down = 0;
   int m_hi[2] = '{0, 0};
   int m_lo[2] = '{0, 0};
   bit m_bot = 0;

   function automatic int sat(input int c);
      return (c == -2048) ? MIN : c;
   endfunction

   function automatic int duty_cycles(input int h);
      int n = 2 * (h - MIN) - 1;
      return (n < 0) ? 0 : n;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step();
      if (rst) begin
         m_cnt = 0; m_down = 0; m_hi = '{0, 0}; m_lo = '{0, 0}; m_bot = 0;
      end else begin
         m_bot = step_en && m_down && (m_cnt == MIN);
         if (step_en) begin
            if (!m_down) begin
               if (m_cnt == MAX) begin m_down = 1; m_cnt--; end
               else m_cnt++;
            end else begin
               if (m_cnt == MIN) begin
                  m_down = 0; m_cnt++;
                  m_hi[0] = sat(int'(cmd_a)); m_lo[0] = -m_hi[0];
                  m_hi[1] = sat(int'(cmd_b)); m_lo[1] = -m_hi[1];
               end else m_cnt--;
            end
         end
      end
   endtask

   task automatic check_all(input string phase);
      check({"R2/R3 carrier ", phase}, int'(carrier), m_cnt);
      check({"R8 bottom_pulse ", phase}, int'(bottom_pulse), int'(m_bot));
      check({"R5 gate_a_left ", phase}, int'(gate_a_left), int'(m_hi[0] > m_cnt));
      check({"R6 gate_a_right ", phase}, int'(gate_a_right), int'(m_lo[0] > m_cnt));
      check({"R5 gate_b_left ", phase}, int'(gate_b_left), int'(m_hi[1] > m_cnt));
      check({"R6 gate_b_right ", phase}, int'(gate_b_right), int'(m_lo[1] > m_cnt));
   endtask

   task automatic cycle(input string phase);
      model_step();
      @(posedge clk);
      @(negedge clk);
      check_all(phase);
   endtask

   task automatic run_to_bottom(input string phase);
      for (int i = 0; i < 20000; i++) begin
         cycle(phase);
         if (bottom_pulse) break;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int la, ra;
      void'($urandom(32'd20240611));
      @(negedge clk);
      // R1: reset state
      rst = 1'b1; step_en = 1'b1; cmd_a = 12'sd500;
      cycle("R1");
      cycle("R1");
      check("R1 carrier", int'(carrier), 0);
      check("R1 gates", int'({gate_a_left, gate_a_right, gate_b_left, gate_b_right}), 0);
      rst = 1'b0;

      // R2: irregular enable, commands constant
      for (int i = 0; i < 300; i++) begin
         step_en = ($urandom % 2) == 0;
         cycle("R2");
      end

      // R3: continuous stepping through top and bottom turnaround
      step_en = 1'b1; cmd_a = 12'sd1000; cmd_b = -12'sd500;
      run_to_bottom("R3");
      check("R8 carrier at bottom pulse", int'(carrier), MIN + 1);

      // R9: duty over one full period
      la = 0; ra = 0;
      for (int i = 0; i < 8188; i++) begin
         la += int'(gate_a_left);
         ra += int'(gate_a_right);
         cycle("R9");
      end
      check("R9 left duty count", la, duty_cycles(1000));
      check("R9 right duty count", ra, duty_cycles(-1000));
      check("R9 period ends at bottom pulse", int'(bottom_pulse), 1);

      // R4: commands churn every cycle mid-period; gates keep latched value
      for (int i = 0; i < 8000; i++) begin
         cmd_a = 12'($urandom);
         cmd_b = 12'($urandom);
         cycle("R4");
      end
      check("R4 thresholds unchanged mid-period", int'(gate_a_left), int'(1000 > m_cnt));

      // R7: most negative command saturates, max command
      cmd_a = -12'sd2048; cmd_b = 12'sd2047;
      run_to_bottom("R7");
      for (int i = 0; i < 8188; i++) begin
         if (m_cnt == MAX - 1)
            check("R7 right gate above 2046", int'(gate_a_right), 1);
         if (m_cnt == MIN + 1)
            check("R7 left gate at -2046", int'(gate_a_left), 0);
         cycle("R7");
      end

      // random mix with extremes
      for (int i = 0; i < 25000; i++) begin
         step_en = ($urandom % 4) != 0;
         case ($urandom % 8)
            0: cmd_a = -12'sd2048;
            1: cmd_a = 12'sd2047;
            default: cmd_a = 12'($urandom);
         endcase
         cmd_b = 12'($urandom);
         cycle("random");
      end

      // R1: reset in mid-run
      rst = 1'b1;
      cycle("R1");
      cycle("R1");
      rst = 1'b0;
      check("R1 mid-run reset carrier", int'(carrier), 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule